// File: doc/BRIEF.md
# Guest Log Line Assembler

This block collects a stream of text bytes written one at a time by a register interface and assembles them into lines. Each byte is stored in a line buffer at a running write offset. When a line completes, the block marks the end of the line with a zero byte and drives the whole line out as one record on a byte stream, from the first stored byte through the zero. A downstream logger or host-side agent consumes the records. The block does not interpret characters beyond detecting the line-feed code.

A line completes in one of two ways. A line-feed byte (0x0A) ends the line and is not stored. A byte that arrives when only the reserved terminator slot is left also ends the line, and that byte is dropped. After the record has gone out, the offset is back at zero and the next byte starts a new line.

Both sides are valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. While a record is being sent the input side holds its ready low, so the writer stalls and loses nothing. On the output side, the block keeps a presented byte and its last flag unchanged until the consumer takes it. The consumer may hold its ready low for any number of cycles.

Top module: `log_line_asm`

## Requirements
- R1: A synchronous active-low reset, sampled at a rising edge, returns the block to accepting input (in_ready high, out_valid low, offset 0). This holds even in the middle of a record, and the rest of that record is discarded.
- R2: An accepted byte other than 0x0A, arriving while the offset is below DEPTH-1, is stored at the current offset and the offset advances by one. Stored bytes leave in the order they were written, starting with the byte written at offset 0.
- R3: An accepted 0x0A byte ends the line and is not stored. The record that follows is the stored bytes and then one 0x00 byte. out_last is 1 on that 0x00 byte and 0 on every other byte.
- R4: A 0x0A accepted at offset 0 produces a record made of one 0x00 byte with out_last set to 1.
- R5: A byte accepted while the offset equals DEPTH-1 (4095 by default) ends the line and is discarded. The record is the DEPTH-1 stored bytes and then 0x00, which is DEPTH bytes in all.
- R6: in_ready is low from the edge that accepts a line-ending byte until the edge that transfers the record's last byte. It is high in the cycle after that edge, and the offset is 0 then.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_last hold their values on the next cycle.
- R8: A byte offered while a record is being sent is held off, not lost. It is accepted once the record ends and becomes byte 0 of the next line.
- R9: out_valid is low whenever no record is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Writer offers a byte |
| in_data | input | 8 | Offered text byte |
| in_ready | output | 1 | Block can take a byte (low while a record is sent) |
| out_valid | output | 1 | A record byte is presented |
| out_data | output | 8 | Record byte |
| out_last | output | 1 | Presented byte is the terminating zero |
| out_ready | input | 1 | Consumer takes the presented byte |

## Verification
The hardest situation to reach from the ports is the full-buffer flush. Reaching it takes DEPTH-1 ordinary bytes with no line feed among them, followed by one more byte that must vanish. The bench writes a long run of printable bytes, confirms that nothing has come out and that in_ready is still high, then sends a marker byte. It checks that the DEPTH-byte record ends in the terminator and does not contain the marker. A short line after that shows the offset was rewound. A stall that overlaps a record needs the consumer held off while a second byte is already offered, so a concurrent task releases out_ready only after the writer is blocked.

// File: rtl/llb_pkg.sv
package llb_pkg;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_FLUSH = 1'b1
  } fill_state_e;

  localparam logic [7:0] LINE_END_CODE = 8'h0A;
  localparam logic [7:0] TERM_CODE     = 8'h00;

endpackage

// File: rtl/llb_line_ram.sv
// Line storage: one write port, one read port with registered read data.
module llb_line_ram #(
  parameter int DEPTH  = 4096,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/llb_fill_ctrl.sv
// Write side: offset counter, line-end detection and the fill/flush state.
module llb_fill_ctrl
  import llb_pkg::*;
#(
  parameter int DEPTH  = 4096,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              drain_done,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic              flush_start,
  output logic [ADDR_W-1:0] flush_len,
  output logic [ADDR_W-1:0] wr_ptr
);

  localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(DEPTH - 1);

  fill_state_e       state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              accept;
  logic              is_line_end;
  logic              at_limit;
  logic              trigger;

  assign in_ready    = (state_q == ST_FILL);
  assign accept      = in_valid && in_ready;
  assign is_line_end = (in_data == LINE_END_CODE);
  assign at_limit    = (ptr_q == LAST_SLOT);
  assign trigger     = accept && (is_line_end || at_limit);

  // The ending byte writes the terminator in place of itself.
  assign ram_we      = accept;
  assign ram_waddr   = ptr_q;
  assign ram_wdata   = trigger ? TERM_CODE : in_data;
  assign flush_start = trigger;
  assign flush_len   = ptr_q;
  assign wr_ptr      = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_FILL: begin
          if (trigger) begin
            state_q <= ST_FLUSH;
          end else if (accept) begin
            ptr_q <= ptr_q + ADDR_W'(1);
          end
        end
        ST_FLUSH: begin
          if (drain_done) begin
            state_q <= ST_FILL;
            ptr_q   <= '0;
          end
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

endmodule

// File: rtl/llb_drain.sv
// Read side: issues buffer reads and feeds a two-entry output queue so the
// stream runs at one byte per cycle despite the one-cycle read latency.
module llb_drain #(
  parameter int DEPTH  = 4096,
  parameter int QDEPTH = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] len,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  input  logic [7:0]        ram_rdata,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  input  logic              out_ready,
  output logic              done
);

  logic              active_q;
  logic              more_q;
  logic [ADDR_W-1:0] rd_ptr_q;
  logic [ADDR_W-1:0] len_q;
  logic              pend_q;
  logic              pend_last_q;

  logic [7:0] q_data [QDEPTH];
  logic       q_last [QDEPTH];
  logic       head_q;
  logic [1:0] cnt_q;

  logic       pop;
  logic [1:0] cnt_after_pop;
  logic [2:0] committed;
  logic       issue;
  logic       tail;

  assign out_valid     = (cnt_q != 2'd0);
  assign out_data      = q_data[head_q];
  assign out_last      = q_last[head_q];
  assign pop           = out_valid && out_ready;
  assign done          = pop && q_last[head_q];
  assign cnt_after_pop = cnt_q - {1'b0, pop};
  assign committed     = {1'b0, cnt_after_pop} + {2'b00, pend_q};
  assign issue         = active_q && more_q && (committed <= 3'd1);
  assign ram_re        = issue;
  assign ram_raddr     = rd_ptr_q;
  assign tail          = head_q ^ cnt_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      more_q      <= 1'b0;
      rd_ptr_q    <= '0;
      len_q       <= '0;
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
      head_q      <= 1'b0;
      cnt_q       <= 2'd0;
    end else begin
      if (start) begin
        active_q <= 1'b1;
        more_q   <= 1'b1;
        rd_ptr_q <= '0;
        len_q    <= len;
      end else begin
        if (done) active_q <= 1'b0;
        if (issue) begin
          if (rd_ptr_q == len_q) more_q <= 1'b0;
          else                   rd_ptr_q <= rd_ptr_q + ADDR_W'(1);
        end
      end
      pend_q      <= issue;
      pend_last_q <= issue && (rd_ptr_q == len_q);
      head_q      <= head_q ^ pop;
      cnt_q       <= cnt_after_pop + {1'b0, pend_q};
    end
  end

  for (genvar g = 0; g < QDEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_data[g] <= 8'h00;
        q_last[g] <= 1'b0;
      end else if (pend_q && (tail == 1'(g))) begin
        q_data[g] <= ram_rdata;
        q_last[g] <= pend_last_q;
      end
    end
  end

endmodule

// File: rtl/log_line_asm.sv
module log_line_asm #(
  parameter int DEPTH = 4096,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  input  logic       out_ready
);

  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [7:0]        ram_wdata;
  logic              ram_re;
  logic [ADDR_W-1:0] ram_raddr;
  logic [7:0]        ram_rdata;
  logic              flush_start;
  logic [ADDR_W-1:0] flush_len;
  logic              drain_done;
  logic [ADDR_W-1:0] fill_ptr;

  llb_fill_ctrl #(.DEPTH(DEPTH)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .drain_done (drain_done),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .flush_start(flush_start),
    .flush_len  (flush_len),
    .wr_ptr     (fill_ptr)
  );

  llb_line_ram #(.DEPTH(DEPTH), .DATA_W(8)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (ram_re),
    .raddr(ram_raddr),
    .rdata(ram_rdata)
  );

  llb_drain #(.DEPTH(DEPTH)) u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (flush_start),
    .len      (flush_len),
    .ram_re   (ram_re),
    .ram_raddr(ram_raddr),
    .ram_rdata(ram_rdata),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last),
    .out_ready(out_ready),
    .done     (drain_done)
  );

endmodule

// File: rtl/log_line_asm_chk.sv
module log_line_asm_chk #(
  parameter int DEPTH = 4096,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [7:0]        in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic              out_last,
  input logic              out_ready,
  input logic [ADDR_W-1:0] fill_ptr
);

  localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(DEPTH - 1);

  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !out_valid && fill_ptr == '0));

  // R2
  a_r2_store_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data != 8'h0A && fill_ptr != LAST_SLOT)
    |=> (in_ready && fill_ptr == $past(fill_ptr) + ADDR_W'(1)));

  // R3
  a_r3_line_end_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_data == 8'h0A)
    |=> (!in_ready && fill_ptr == $past(fill_ptr)));

  // R3
  a_r3_term_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_data == 8'h00));

  // R5
  a_r5_full_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && fill_ptr == LAST_SLOT) |=> !in_ready);

  // R6
  a_r6_busy_while_out: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R6
  a_r6_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && fill_ptr == '0));

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready)
    |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

endmodule

bind log_line_asm log_line_asm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_data  (in_data),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_last (out_last),
  .out_ready(out_ready),
  .fill_ptr (fill_ptr)
);

// File: tb/log_line_asm_tb.sv
`timescale 1ns/1ps
module log_line_asm_tb;

  localparam int DEPTH = 4096;
  localparam int CAP   = DEPTH + 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_ready = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] cap_data [CAP];
  logic       cap_last [CAP];
  int         cap_cnt = 0;
  logic       got_last = 1'b0;
  logic [7:0] exp_data [CAP];
  int         exp_cnt = 0;
  int         rdy_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  always #2 clk = ~clk;

  log_line_asm #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .out_ready(out_ready)
  );

  // Consumer: picks out_ready for the next edge, records the transfer there.
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = 1'b0;
      2:       out_ready = ~out_ready;
      default: out_ready = lfsr[0];
    endcase
    if (out_valid && out_ready && cap_cnt < CAP) begin
      cap_data[cap_cnt] = out_data;
      cap_last[cap_cnt] = out_last;
      if (out_last) got_last = 1'b1;
      cap_cnt++;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_cap();
    cap_cnt = 0; got_last = 1'b0; exp_cnt = 0;
  endtask

  task automatic expect_byte(input logic [7:0] b);
    exp_data[exp_cnt] = b; exp_cnt++;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_line(input string s);
    for (int i = 0; i < s.len(); i++) begin
      send(s[i]); expect_byte(s[i]);
    end
    send(8'h0A); expect_byte(8'h00);
  endtask

  task automatic wait_done(input string req);
    while (!got_last) @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, {req, " in_ready after record"}, int'(in_ready), 1);
    check(out_valid == 1'b0, "R9 out_valid idle", int'(out_valid), 0);
  endtask

  // Compare the captured record to the expected bytes; last only on the final one.
  task automatic check_record(input string req);
    int bad = -1;
    check(cap_cnt == exp_cnt, {req, " record length"}, cap_cnt, exp_cnt);
    for (int i = 0; i < exp_cnt && i < cap_cnt; i++) begin
      if (bad < 0 && (cap_data[i] !== exp_data[i] || cap_last[i] !== (i == exp_cnt - 1)))
        bad = i;
    end
    check(bad < 0, {req, " record bytes (first bad index as actual)"}, bad, -1);
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_basic();
    rdy_mode = 0; clear_cap();
    send_line("Hi!");
    wait_done("R6");
    check_record("R2 R3 basic line");
  endtask

  task automatic t_empty();
    rdy_mode = 0; clear_cap();
    send_line("");
    wait_done("R6");
    check_record("R4 empty line");
  endtask

  task automatic t_backpressure();
    rdy_mode = 2; clear_cap();
    send_line("0123456789");
    wait_done("R6");
    check_record("R7 alternating ready");
    rdy_mode = 3; clear_cap();
    send_line("the quick brown fox");
    wait_done("R6");
    check_record("R7 random ready");
  endtask

  task automatic t_stall();
    rdy_mode = 1; clear_cap();
    send_line("AB");
    repeat (5) @(negedge clk);
    check(in_ready == 1'b0, "R6 in_ready low during record", int'(in_ready), 0);
    check(out_valid == 1'b1 && out_data == 8'h41, "R7 first byte held",
          int'(out_data), 32'h41);
    fork
      send(8'h51);
      begin repeat (4) @(negedge clk); rdy_mode = 0; end
    join
    check_record("R8 first line before stalled byte");
    clear_cap();
    send(8'h0A);
    expect_byte(8'h51); expect_byte(8'h00);
    wait_done("R6");
    check_record("R8 stalled byte starts next line");
  endtask

  task automatic t_full();
    logic [7:0] b;
    rdy_mode = 0; clear_cap();
    for (int i = 0; i < DEPTH - 1; i++) begin
      b = 8'((i % 90) + 33);
      send(b); expect_byte(b);
    end
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && cap_cnt == 0, "R5 no flush before limit", cap_cnt, 0);
    send(8'h5A);
    expect_byte(8'h00);
    wait_done("R6");
    check_record("R5 full-buffer record, marker dropped");
    clear_cap();
    send_line("k");
    wait_done("R6");
    check_record("R5 R6 offset rewound after full flush");
  endtask

  task automatic t_reset_abort();
    rdy_mode = 1; clear_cap();
    send_line("abc");
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after abort", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid after abort", int'(out_valid), 0);
    rst_n = 1'b1;
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && cap_cnt == 0, "R1 aborted record dropped", cap_cnt, 0);
    clear_cap();
    send_line("x");
    wait_done("R6");
    check_record("R1 fresh line after abort");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_empty();
    t_backpressure();
    t_stall();
    t_full();
    t_reset_abort();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule